// File: doc/BRIEF.md
# System ROM Remap Decoder

This block sits on the host side of an expansion card and decodes the 20-bit memory address of each host read. Its job is to decide whether on-card flash answers the cycle and which 16 KB page of that flash the cycle lands in. Two regions can be served. The first is a fixed 16 KB option ROM window. The second is the whole 64 KB system ROM region at the top of the address space. The system region is taken over as one block or left alone, and a switch chooses which of two 64 KB flash images fills it. When the card takes the system region, it raises a claim signal that keeps the motherboard ROM off the bus.

The upper flash address lines share board pins with another data bus. For that reason the block drives them, together with a drive-enable, only while the flash chip enable is active. The three option switches (system remap, image select, option window enable) are captured only while reset is held. The memory map therefore stays fixed for the whole run that follows. Outside the two windows nothing is mapped.

Top module: `rom_remap_decoder`

## Requirements
- R1: While `rst_n` is low, the outputs are idle: `flash_ce_n` = 1, `bus_claim` = 0, `page_oe` = 0, and `flash_page` and `flash_low` are both zero.
- R2: With remap latched on, a read (`mem_rd` = 1) at any address F0000h to FFFFFh gives `flash_ce_n` = 0 and `bus_claim` = 1. `flash_low` equals address bits 13:0.
- R3: For such a system read, `flash_page` = {slot, address bits 15:14}. The slot is `SYS_SLOT0` (default 6) when the latched image select is 0, and `SYS_SLOT1` (default 7) when it is 1. The slot occupies the upper page bits.
- R4: With remap latched off, reads in F0000h to FFFFFh give `bus_claim` = 0 and `flash_ce_n` = 1, so the motherboard ROM answers.
- R5: With the option window latched on, a read in the 16 KB window starting at `OPT_BASE` (default D8000h) gives `flash_ce_n` = 0, `bus_claim` = 0 and `flash_page` = `OPT_SLOT` (default 0). `flash_low` equals address bits 13:0.
- R6: The option window decodes the same way whether remap is latched on or off. Image select has no effect on it.
- R7: A read at any address outside the enabled windows, including the bytes just beside a window edge, leaves `flash_ce_n` = 1 and `bus_claim` = 0.
- R8: Switch inputs are captured only while `rst_n` is low. Changing them after reset does not change any decode.
- R9: `page_oe` equals the inverse of `flash_ce_n`. While `page_oe` is 0, `flash_page` and `flash_low` are zero.
- R10: With `mem_rd` = 0, no region is selected: `flash_ce_n` = 1 and `bus_claim` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to capture the switches |
| rst_n | input | 1 | Active-low reset; switches are sampled while it is low |
| host_addr | input | 20 | Host memory address |
| mem_rd | input | 1 | Host memory read strobe, active high |
| sw_remap | input | 1 | Switch: take over the top 64 KB system region |
| sw_image | input | 1 | Switch: which of the two flash images serves the system region |
| sw_optrom | input | 1 | Switch: enable the 16 KB option ROM window |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| page_oe | output | 1 | Drive-enable for the shared page pins |
| flash_page | output | 5 | Flash address bits 18:14 |
| flash_low | output | 14 | Flash address bits 13:0 |
| bus_claim | output | 1 | Overrides the motherboard ROM for the system region |

## Verification
The assertions assume that the switch inputs are steady for at least one clock before reset is released. They also assume that the address and read strobe are settled whenever the outputs are sampled, because the decode is combinational. The stimulus keeps to this. Switches are set, several clocks of reset follow, and reset is released on a falling edge. After that the switches are toggled at random to probe the latch. Addresses and strobes are changed only on falling edges and are observed one nanosecond later. Random addresses are biased toward the two windows and their neighbouring bytes.

// File: rtl/rr_pkg.sv
package rr_pkg;

   typedef struct packed {
      logic remap;
      logic image;
      logic optrom;
   } rr_cfg_t;

   localparam rr_cfg_t RR_CFG_IDLE = '{remap: 1'b0, image: 1'b0, optrom: 1'b0};

   // number of address bits that select a window of 2**span bytes
   function automatic int rr_tag_bits(input int addr_w, input int span_log2);
      return addr_w - span_log2;
   endfunction

endpackage

// File: rtl/rr_cfg_latch.sv
module rr_cfg_latch
   import rr_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    sw_remap,
   input  logic    sw_image,
   input  logic    sw_optrom,
   output rr_cfg_t cfg_o
);

   rr_cfg_t cfg_q;

   // capture happens only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q.remap  <= sw_remap;
         cfg_q.image  <= sw_image;
         cfg_q.optrom <= sw_optrom;
      end
   end

   assign cfg_o = cfg_q;

   // R8: map frozen once reset is released
   a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(cfg_q));

endmodule

// File: rtl/rr_window.sv
module rr_window
   import rr_pkg::*;
#(
   parameter int          ADDR_W    = 20,
   parameter logic [19:0] BASE      = 20'hF0000,
   parameter int          SPAN_LOG2 = 16
)(
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);

   localparam int TAG_W = rr_tag_bits(ADDR_W, SPAN_LOG2);

   generate
      if (SPAN_LOG2 < 1 || SPAN_LOG2 > ADDR_W) begin : g_bad
         $error("rr_window: span out of range");
      end
      if (TAG_W == 0) begin : g_all
         assign hit = 1'b1;
      end else begin : g_cmp
         localparam logic [ADDR_W-1:0] BASE_W = BASE[ADDR_W-1:0];
         if ((BASE_W & ((ADDR_W'(1) << SPAN_LOG2) - ADDR_W'(1))) != '0) begin : g_align
            $error("rr_window: base not aligned to span");
         end
         assign hit = (addr[ADDR_W-1:SPAN_LOG2] == BASE_W[ADDR_W-1:SPAN_LOG2]);
      end
   endgenerate

endmodule

// File: rtl/rr_page_mux.sv
module rr_page_mux #(
   parameter int PAGE_W    = 5,
   parameter int SYS_SLOT0 = 6,
   parameter int SYS_SLOT1 = 7,
   parameter int OPT_SLOT  = 0
)(
   input  logic              sys_sel,
   input  logic              opt_sel,
   input  logic              image,
   input  logic [1:0]        sub_page,
   input  logic [13:0]       addr_low,
   output logic              oe,
   output logic [PAGE_W-1:0] page,
   output logic [13:0]       low
);

   localparam int SLOT_W = PAGE_W - 2;

   logic [SLOT_W-1:0] slot;
   logic [PAGE_W-1:0] sys_page;

   generate
      if (SLOT_W < 1) begin : g_bad
         $error("rr_page_mux: flash too small for two system images");
      end
      if (SYS_SLOT0 >= (1 << SLOT_W) || SYS_SLOT1 >= (1 << SLOT_W)) begin : g_slot
         $error("rr_page_mux: system slot beyond flash");
      end
      if (OPT_SLOT >= (1 << PAGE_W)) begin : g_opt
         $error("rr_page_mux: option slot beyond flash");
      end
      if (SYS_SLOT0 == SYS_SLOT1) begin : g_same
         assign slot = SLOT_W'(SYS_SLOT0);
      end else begin : g_two
         assign slot = image ? SLOT_W'(SYS_SLOT1) : SLOT_W'(SYS_SLOT0);
      end
   endgenerate

   assign sys_page = {slot, sub_page};

   always_comb begin
      oe   = 1'b0;
      page = '0;
      low  = '0;
      if (sys_sel) begin
         oe   = 1'b1;
         page = sys_page;
         low  = addr_low;
      end else if (opt_sel) begin
         oe   = 1'b1;
         page = PAGE_W'(OPT_SLOT);
         low  = addr_low;
      end
   end

endmodule

// File: rtl/rom_remap_decoder.sv
module rom_remap_decoder
   import rr_pkg::*;
#(
   parameter int          FLASH_AW  = 19,
   parameter int          SYS_SLOT0 = 6,
   parameter int          SYS_SLOT1 = 7,
   parameter int          OPT_SLOT  = 0,
   parameter logic [19:0] OPT_BASE  = 20'hD8000
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [19:0]            host_addr,
   input  logic                   mem_rd,
   input  logic                   sw_remap,
   input  logic                   sw_image,
   input  logic                   sw_optrom,
   output logic                   flash_ce_n,
   output logic                   page_oe,
   output logic [FLASH_AW-15:0]   flash_page,
   output logic [13:0]            flash_low,
   output logic                   bus_claim
);

   localparam int          ADDR_W   = 20;
   localparam int          PAGE_W   = FLASH_AW - 14;
   localparam logic [19:0] SYS_BASE = 20'hF0000;

   generate
      if (OPT_BASE[19:16] == SYS_BASE[19:16]) begin : g_overlap
         $error("rom_remap_decoder: option window inside system region");
      end
      if (FLASH_AW < 17) begin : g_small
         $error("rom_remap_decoder: flash address too narrow");
      end
   endgenerate

   rr_cfg_t cfg;
   logic    sys_win, opt_win;
   logic    run, sys_sel, opt_sel;

   rr_cfg_latch u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_remap  (sw_remap),
      .sw_image  (sw_image),
      .sw_optrom (sw_optrom),
      .cfg_o     (cfg)
   );

   rr_window #(.ADDR_W(ADDR_W), .BASE(SYS_BASE), .SPAN_LOG2(16)) u_sys_win (
      .addr (host_addr),
      .hit  (sys_win)
   );

   rr_window #(.ADDR_W(ADDR_W), .BASE(OPT_BASE), .SPAN_LOG2(14)) u_opt_win (
      .addr (host_addr),
      .hit  (opt_win)
   );

   assign run     = rst_n & mem_rd;
   assign sys_sel = run & cfg.remap & sys_win;
   assign opt_sel = run & cfg.optrom & opt_win;

   rr_page_mux #(
      .PAGE_W    (PAGE_W),
      .SYS_SLOT0 (SYS_SLOT0),
      .SYS_SLOT1 (SYS_SLOT1),
      .OPT_SLOT  (OPT_SLOT)
   ) u_mux (
      .sys_sel  (sys_sel),
      .opt_sel  (opt_sel),
      .image    (cfg.image),
      .sub_page (host_addr[15:14]),
      .addr_low (host_addr[13:0]),
      .oe       (page_oe),
      .page     (flash_page),
      .low      (flash_low)
   );

   assign flash_ce_n = ~(sys_sel | opt_sel);
   assign bus_claim  = sys_sel;

   // R2: claim only on reads in the top 64 KB
   a_r2_claim_region: assert property (@(posedge clk) disable iff (!rst_n)
      bus_claim |-> (mem_rd && host_addr[19:16] == 4'hF && !flash_ce_n));

   // R4: no claim while remap is latched off
   a_r4_no_claim_off: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.remap |-> !bus_claim);

   // R5: option selection uses the option slot
   a_r5_opt_page: assert property (@(posedge clk) disable iff (!rst_n)
      (!flash_ce_n && !bus_claim) |-> (flash_page == PAGE_W'(OPT_SLOT)));

   // R9: shared pins quiet when flash not enabled
   a_r9_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (page_oe == !flash_ce_n) && (!page_oe -> (flash_page == '0 && flash_low == '0)));

   // R10: no selection without a read strobe
   a_r10_need_read: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_rd |-> (flash_ce_n && !bus_claim));

endmodule

// File: tb/rom_remap_decoder_bench.sv
module rom_remap_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] host_addr = '0;
   logic        mem_rd = 1'b0;
   logic        sw_remap = 1'b0, sw_image = 1'b0, sw_optrom = 1'b0;
   logic        flash_ce_n, page_oe, bus_claim;
   logic [4:0]  flash_page;
   logic [13:0] flash_low;

   int n_vec = 0;
   int n_bad = 0;
   logic l_remap, l_image, l_opt;

   always #2 clk = ~clk;

   rom_remap_decoder u_rom_remap_decoder (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .mem_rd(mem_rd),
      .sw_remap(sw_remap), .sw_image(sw_image), .sw_optrom(sw_optrom),
      .flash_ce_n(flash_ce_n), .page_oe(page_oe), .flash_page(flash_page),
      .flash_low(flash_low), .bus_claim(bus_claim)
   );

   // packed result: {ce_n, oe, claim, page[4:0], low[13:0]}
   function automatic logic [21:0] expect_out(input logic [19:0] a, input logic rd,
                                              input logic rm, input logic im, input logic op);
      logic sys, opt;
      sys = rd && rm && (a[19:16] == 4'hF);
      opt = rd && op && (a[19:14] == 6'b110110);   // D8000h..DBFFFh
      if (sys)      return {1'b0, 1'b1, 1'b1, (im ? 3'd7 : 3'd6), a[15:14], a[13:0]};
      else if (opt) return {1'b0, 1'b1, 1'b0, 5'd0, a[13:0]};
      else          return {1'b1, 1'b0, 1'b0, 5'd0, 14'd0};
   endfunction

   function automatic string tag_of(input logic [19:0] a, input logic rd,
                                    input logic rm, input logic op);
      if (!rd) return "R10";
      if (a[19:16] == 4'hF) return rm ? "R2/R3" : "R4";
      if (a[19:14] == 6'b110110) return op ? (rm ? "R5" : "R6") : "R7";
      return "R7";
   endfunction

   task automatic check(input string tag, input logic [21:0] exp);
      logic [21:0] got;
      got = {flash_ce_n, page_oe, bus_claim, flash_page, flash_low};
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s addr=%h rd=%0b got=%h expected=%h", tag, host_addr, mem_rd, got, exp);
      end
   endtask

   task automatic apply(input logic [19:0] a, input logic rd);
      @(negedge clk);
      host_addr = a;
      mem_rd    = rd;
      #1;
      check(tag_of(a, rd, l_remap, l_opt), expect_out(a, rd, l_remap, l_image, l_opt));
   endtask

   task automatic do_reset(input logic rm, input logic im, input logic op);
      @(negedge clk);
      rst_n = 1'b0;
      sw_remap = rm; sw_image = im; sw_optrom = op;
      mem_rd = 1'b1; host_addr = 20'hF1234;
      repeat (3) @(posedge clk);
      #1;
      check("R1", {1'b1, 1'b0, 1'b0, 5'd0, 14'd0});   // R1 idle in reset
      @(negedge clk);
      rst_n = 1'b1;
      l_remap = rm; l_image = im; l_opt = op;
      // R8: switches now change, map must not follow
      sw_remap = ~rm; sw_image = ~im; sw_optrom = ~op;
   endtask

   function automatic logic [19:0] pick_addr();
      logic [19:0] a;
      a = 20'($urandom);
      case ($urandom % 6)
         0: a[19:16] = 4'hF;
         1: a[19:14] = 6'b110110;
         2: a = 20'hD8000 - 20'(($urandom % 4) + 1);
         3: a = 20'hDC000 + 20'($urandom % 4);
         4: a = 20'hEFFFF - 20'($urandom % 4);
         default: ;
      endcase
      return a;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd20110620));
      for (int cfg = 0; cfg < 8; cfg++) begin
         do_reset(cfg[2], cfg[1], cfg[0]);
         // directed window edges: R2 R3 R4 R5 R6 R7
         apply(20'hF0000, 1'b1);
         apply(20'hFFFFF, 1'b1);
         apply(20'hF8000, 1'b1);
         apply(20'hEFFFF, 1'b1);
         apply(20'hD8000, 1'b1);
         apply(20'hDBFFF, 1'b1);
         apply(20'hD7FFF, 1'b1);
         apply(20'hDC000, 1'b1);
         apply(20'h00000, 1'b1);
         apply(20'hFFFFF, 1'b0);   // R10
         apply(20'hD8000, 1'b0);   // R10
         for (int i = 0; i < 200; i++) begin
            if (i % 16 == 0) begin
               sw_remap = 1'($urandom); sw_image = 1'($urandom); sw_optrom = 1'($urandom); // R8
            end
            apply(pick_addr(), ($urandom % 5) != 0);
         end
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule